// File: doc/BRIEF.md
# PCM Voice Serial Port with G.711 Companding

This block is a full-duplex serial port for a single voice channel. It connects a 14-bit two's-complement sample path to a bit-serial PCM link that is framed by a frame-sync pulse. Each frame it takes one transmit sample, codes it, and shifts the result out MSB first on `dx`. In the same frame it shifts a word in from `dr`, decodes it, and presents a 14-bit receive sample with a one-cycle strobe.

The whole block runs on the serial bit clock `clk`. The bit clock may run at any multiple of the 64 kHz base rate while the frame rate stays the same. The bit clock is therefore the only time reference, and the frame length in bit clocks is not fixed.

Three word formats are available:
- 8-bit A-law.
- 8-bit mu-law.
- 16-bit linear.

Two frame alignments are available. The first data bit can coincide with the frame-sync edge, or it can follow one bit clock later. A frame sync that arrives while a word is still moving restarts the frame and leaves a sticky error flag.

Top module: `pcm_voice_port`

## Requirements
- R1: While `rst_n` is low and after it is released, `dxOe`, `dx`, `rxValid`, `frameErr` and `rxSample` are all 0.
- R2: The format code is `fmtSel`: 2'b00 is A-law (8 bits), 2'b01 is mu-law (8 bits), and 2'b10 or 2'b11 is linear (16 bits). It is sampled at the frame start, so a change during a frame does not affect the transmit word or the receive decode of that frame.
- R3: With `alignFs`=1, a frame starts on the `clk` edge that first samples `fs` high. The MSB is driven on `dx` during the cycle after that edge, and the next edge captures the MSB from `dr`.
- R4: With `alignFs`=0, everything in R3 happens one `clk` edge later. `dxOe` stays low during the cycle after the edge that first samples `fs` high.
- R5: `dxOe` is high for exactly 8 cycles (companded) or 16 cycles (linear), one bit per cycle, MSB first. `dx` is 0 whenever `dxOe` is low.
- R6: In linear mode the transmit word is the 14-bit sample sign-extended to 16 bits. On receive, the sample is bits [13:0] of the 16-bit word.
- R7: mu-law compression does the following, in order:
  - takes the magnitude of the 14-bit sample and clips it to 8159;
  - adds 33;
  - sets the segment to the position of the highest set bit minus 5 (a value of 8192 yields the code 0x7F before inversion);
  - takes 4 mantissa bits below that highest bit;
  - inverts all bits for positive samples and bits [6:0] for negative samples.
- R8: A-law compression does the following, in order:
  - uses sample bits [13:1];
  - takes the one's complement of the magnitude for negative samples;
  - sets the segment to the position of the highest set bit minus 4, with a floor of 0;
  - takes 4 mantissa bits, shifting by the segment with a minimum shift of 1;
  - XORs the code with 0xD5 for positive samples and 0x55 for negative samples.
- R9: Expansion follows G.711, scaled to 14 bits.
  - mu-law: invert the code, then the magnitude is ((2m+33)<<e)-33, and the sample is negative when bit 7 of the inverted code is set.
  - A-law: XOR the code with 0x55. The value is t=16m+8 for e=0, or (16m+264)<<(e-1) otherwise. The sample is t/4, negated when bit 7 is clear.
- R10: `rxValid` is high for exactly one cycle, the cycle after the edge that captures the last bit. `rxSample` holds the decoded word from that cycle until the next strobe.
- R11: A frame start that arrives while a frame is still shifting, before its last bit, restarts the frame and sets `frameErr`. `frameErr` stays set until reset and is never set by complete frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fs | input | 1 | Frame sync; a frame begins on its rising edge |
| fmtSel | input | 2 | Word format: 00 A-law, 01 mu-law, 1x linear |
| alignFs | input | 1 | 1: MSB aligned with the sync edge; 0: MSB one clock later |
| txSample | input | 14 | Transmit sample, two's complement, sampled at frame start |
| dr | input | 1 | Serial receive data |
| dx | output | 1 | Serial transmit data, 0 when not enabled |
| dxOe | output | 1 | Output enable for `dx` during active bit slots |
| rxSample | output | 14 | Decoded receive sample, two's complement |
| rxValid | output | 1 | One-cycle strobe marking a new `rxSample` |
| frameErr | output | 1 | Sticky flag for a frame restarted before completion |

## Verification
The bit counter and the latched format decide both the length of the `dxOe` window and the cycle of `rxValid`. A bad counter or format register therefore shows up within one frame, as a window of the wrong length or a strobe in the wrong cycle. A wrong segment or mantissa path corrupts the bits seen on `dx` in the same frame, or the `rxSample` presented at the end of it. An alignment error shifts the first enabled cycle by one relative to the sync edge, so each frame is checked cycle by cycle against that edge. A lost restart shows up at the next early sync as a `frameErr` that stays low, or as a receive word assembled from two frames.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int LIN_W  = 14;
  localparam int WORD_W = 16;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    FMT_ALAW  = 2'b00,
    FMT_MULAW = 2'b01,
    FMT_LIN   = 2'b10,
    FMT_LINX  = 2'b11
  } fmt_e;

  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
    logic lastBit;
  } ctrlStrobe_t;
endpackage

// File: rtl/pcm_g711_compress.sv
module pcm_g711_compress
  import pcm_port_pkg::*;
(
  input  logic [LIN_W-1:0]  linIn,
  input  logic              useMu,
  output logic [CODE_W-1:0] codeOut
);
  localparam logic [LIN_W:0]   MU_CLIP = 15'd8159;
  localparam logic [LIN_W-1:0] MU_BIAS = 14'd33;

  logic             muNeg;
  logic [LIN_W:0]   muMag;
  logic [LIN_W-1:0] muClip;
  logic [LIN_W-1:0] muBiased;
  logic [3:0]       muTop;
  logic [2:0]       muSeg;
  logic [LIN_W-1:0] muShifted;
  logic [7:0]       muRaw;
  logic [7:0]       muCode;

  logic             aNeg;
  logic [11:0]      aMag;
  logic [3:0]       aTop;
  logic [2:0]       aSeg;
  logic [3:0]       aShift;
  logic [11:0]      aShifted;
  logic [7:0]       aCode;

  // mu-law: clip, bias, segment search, invert
  always_comb begin
    muNeg  = linIn[LIN_W-1];
    muMag  = muNeg ? (15'd0 - {linIn[LIN_W-1], linIn}) : {1'b0, linIn};
    muClip = (muMag > MU_CLIP) ? MU_CLIP[LIN_W-1:0] : muMag[LIN_W-1:0];
    muBiased = muClip + MU_BIAS;
    muTop = 4'd5;
    for (int i = 6; i < LIN_W; i++) begin
      if (muBiased[i]) muTop = 4'(i);
    end
    muSeg     = 3'(muTop - 4'd5);
    muShifted = muBiased >> (muTop - 4'd4);
    muRaw     = (muTop == 4'd13) ? 8'h7F : {1'b0, muSeg, muShifted[3:0]};
    muCode    = muRaw ^ (muNeg ? 8'h7F : 8'hFF);
  end

  // A-law: 13-bit value, one's complement magnitude, alternate-bit mask
  always_comb begin
    aNeg = linIn[LIN_W-1];
    aMag = aNeg ? ~linIn[12:1] : linIn[12:1];
    aTop = 4'd4;
    for (int i = 5; i < 12; i++) begin
      if (aMag[i]) aTop = 4'(i);
    end
    aSeg     = 3'(aTop - 4'd4);
    aShift   = (aTop == 4'd4) ? 4'd1 : (aTop - 4'd4);
    aShifted = aMag >> aShift;
    aCode    = {1'b0, aSeg, aShifted[3:0]} ^ (aNeg ? 8'h55 : 8'hD5);
  end

  assign codeOut = useMu ? muCode : aCode;
endmodule

// File: rtl/pcm_g711_expand.sv
module pcm_g711_expand
  import pcm_port_pkg::*;
(
  input  logic [CODE_W-1:0] codeIn,
  input  logic              useMu,
  output logic [LIN_W-1:0]  linOut
);
  logic [7:0]       muU;
  logic [6:0]       muBase;
  logic [LIN_W-1:0] muScaled;
  logic [LIN_W-1:0] muMagX;
  logic [LIN_W-1:0] muLin;

  logic [7:0]       aV;
  logic [7:0]       aBase;
  logic [15:0]      aT;
  logic [LIN_W-1:0] aMagX;
  logic [LIN_W-1:0] aLin;

  always_comb begin
    muU      = ~codeIn;
    muBase   = {2'b00, muU[3:0], 1'b0} + 7'd33;
    muScaled = 14'(muBase) << muU[6:4];
    muMagX   = muScaled - 14'd33;
    muLin    = muU[7] ? (14'd0 - muMagX) : muMagX;
  end

  always_comb begin
    aV    = codeIn ^ 8'h55;
    aBase = {aV[3:0], 4'b0000};
    if (aV[6:4] == 3'd0) aT = 16'(aBase) + 16'd8;
    else                 aT = (16'(aBase) + 16'd264) << (aV[6:4] - 3'd1);
    aMagX = aT[15:2];
    aLin  = aV[7] ? aMagX : (14'd0 - aMagX);
  end

  assign linOut = useMu ? muLin : aLin;
endmodule

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS = WORD_W,
  parameter int CODE_BITS = CODE_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fs,
  input  logic        alignFs,
  input  logic [1:0]  fmtSel,
  output ctrlStrobe_t strobe,
  output logic [1:0]  fmtQ,
  output logic        active,
  output logic        frameErr
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_LIN  = CNT_W'(WORD_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_CODE = CNT_W'(CODE_BITS - 1);

  logic             fsPrev;
  logic             fsRiseD;
  logic             alignD;
  logic [CNT_W-1:0] bitCnt;
  logic             fsRise;
  logic             start;
  logic             lastBit;
  logic [CNT_W-1:0] lastIdx;

  assign fsRise  = fs & ~fsPrev;
  assign start   = (fsRise & alignFs) | (fsRiseD & ~alignD);
  assign lastIdx = fmtQ[1] ? LAST_LIN : LAST_CODE;
  assign lastBit = active && (bitCnt == lastIdx);

  assign strobe.loadFrame = start;
  assign strobe.shiftBit  = active;
  assign strobe.lastBit   = lastBit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsPrev   <= 1'b0;
      fsRiseD  <= 1'b0;
      alignD   <= 1'b1;
      active   <= 1'b0;
      bitCnt   <= '0;
      fmtQ     <= FMT_ALAW;
      frameErr <= 1'b0;
    end else begin
      fsPrev  <= fs;
      fsRiseD <= fsRise;
      if (fsRise) alignD <= alignFs;
      if (start) begin
        active <= 1'b1;
        bitCnt <= '0;
        fmtQ   <= fmtSel;
        if (active && !lastBit) frameErr <= 1'b1;
      end else if (active) begin
        if (lastBit) active <= 1'b0;
        else         bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_port_datapath.sv
module pcm_port_datapath
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS = WORD_W,
  parameter int CODE_BITS = CODE_W,
  parameter int LIN_BITS  = LIN_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobe_t         strobe,
  input  logic [1:0]          fmtSel,
  input  logic [1:0]          fmtQ,
  input  logic [LIN_BITS-1:0] txSample,
  input  logic                dr,
  output logic                txMsb,
  output logic [LIN_BITS-1:0] rxSample,
  output logic                rxValid
);
  localparam int EXT_W = WORD_BITS - LIN_BITS;
  localparam int PAD_W = WORD_BITS - CODE_BITS;

  logic [WORD_BITS-1:0] txShift;
  logic [WORD_BITS-1:0] rxShift;
  logic [WORD_BITS-1:0] txWord;
  logic [WORD_BITS-1:0] rxNext;
  logic [CODE_BITS-1:0] txCode;
  logic [LIN_BITS-1:0]  rxExpanded;
  logic [LIN_BITS-1:0]  rxLin;

  pcm_g711_compress u_comp (
    .linIn  (txSample),
    .useMu  (fmtSel == FMT_MULAW),
    .codeOut(txCode)
  );

  assign rxNext = {rxShift[WORD_BITS-2:0], dr};

  pcm_g711_expand u_exp (
    .codeIn(rxNext[CODE_BITS-1:0]),
    .useMu (fmtQ == FMT_MULAW),
    .linOut(rxExpanded)
  );

  assign txWord = fmtSel[1] ? {{EXT_W{txSample[LIN_BITS-1]}}, txSample}
                            : {txCode, {PAD_W{1'b0}}};
  assign rxLin  = fmtQ[1] ? rxNext[LIN_BITS-1:0] : rxExpanded;
  assign txMsb  = txShift[WORD_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txShift  <= '0;
      rxShift  <= '0;
      rxSample <= '0;
      rxValid  <= 1'b0;
    end else begin
      if (strobe.loadFrame)     txShift <= txWord;
      else if (strobe.shiftBit) txShift <= txShift << 1;
      if (strobe.shiftBit) rxShift <= rxNext;
      rxValid <= strobe.lastBit;
      if (strobe.lastBit) rxSample <= rxLin;
    end
  end
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs,
  input  logic [1:0]        fmtSel,
  input  logic              alignFs,
  input  logic [LIN_W-1:0]  txSample,
  input  logic              dr,
  output logic              dx,
  output logic              dxOe,
  output logic [LIN_W-1:0]  rxSample,
  output logic              rxValid,
  output logic              frameErr
);
  ctrlStrobe_t strobe;
  logic [1:0]  fmtQ;
  logic        active;
  logic        txMsb;

  pcm_port_ctrl #(.WORD_BITS(WORD_W), .CODE_BITS(CODE_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .fs      (fs),
    .alignFs (alignFs),
    .fmtSel  (fmtSel),
    .strobe  (strobe),
    .fmtQ    (fmtQ),
    .active  (active),
    .frameErr(frameErr)
  );

  pcm_port_datapath #(.WORD_BITS(WORD_W), .CODE_BITS(CODE_W), .LIN_BITS(LIN_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .fmtSel  (fmtSel),
    .fmtQ    (fmtQ),
    .txSample(txSample),
    .dr      (dr),
    .txMsb   (txMsb),
    .rxSample(rxSample),
    .rxValid (rxValid)
  );

  assign dxOe = active;
  assign dx   = active & txMsb;
endmodule

// File: rtl/pcm_voice_port_checker.sv
module pcm_voice_port_checker (
  input logic clk,
  input logic rst_n,
  input logic fs,
  input logic alignFs,
  input logic dx,
  input logic dxOe,
  input logic rxValid,
  input logic frameErr
);
  // R5: idle line carries 0
  a_r5_dx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dxOe |-> !dx);

  // R10: strobe lasts one cycle
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);

  // R10: strobe only right after an enabled bit slot
  a_r10_valid_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |-> $past(dxOe));

  // R11: error flag is sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frameErr |=> frameErr);

  // R3: aligned mode enables on the sync edge
  a_r3_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fs) && alignFs) |=> dxOe);

  // R4: delayed mode stays idle one more cycle
  a_r4_start_delayed: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fs) && !alignFs && !dxOe) |=> !dxOe);
endmodule

bind pcm_voice_port pcm_voice_port_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fs      (fs),
  .alignFs (alignFs),
  .dx      (dx),
  .dxOe    (dxOe),
  .rxValid (rxValid),
  .frameErr(frameErr)
);

// File: tb/sim_pcm_voice_port.sv
`timescale 1ns/1ps
module sim_pcm_voice_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic [1:0]  fmtSel = 2'b00;
  logic        alignFs = 1'b1;
  logic [13:0] txSample = '0;
  logic        dr = 1'b0;
  logic        dx;
  logic        dxOe;
  logic [13:0] rxSample;
  logic        rxValid;
  logic        frameErr;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  pcm_voice_port u0 (
    .clk(clk), .rst_n(rst_n), .fs(fs), .fmtSel(fmtSel), .alignFs(alignFs),
    .txSample(txSample), .dr(dr), .dx(dx), .dxOe(dxOe),
    .rxSample(rxSample), .rxValid(rxValid), .frameErr(frameErr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // reference coders, written from the requirement text
  function automatic logic [7:0] refMuEnc(input int x);
    int mag, mask, seg;
    mask = (x < 0) ? 'h7F : 'hFF;
    mag  = (x < 0) ? -x : x;
    if (mag > 8159) mag = 8159;
    mag = mag + 33;
    seg = 8;
    for (int i = 7; i >= 0; i--) if (mag <= ((64 << i) - 1)) seg = i;
    if (seg >= 8) return 8'(8'h7F ^ mask);
    return 8'((((seg << 4) | ((mag >> (seg + 1)) & 15))) ^ mask);
  endfunction

  function automatic logic [7:0] refAEnc(input int x);
    int v, mask, seg, m;
    v = x >>> 1;
    if (v >= 0) mask = 'hD5;
    else begin mask = 'h55; v = -v - 1; end
    seg = 8;
    for (int i = 7; i >= 0; i--) if (v <= ((32 << i) - 1)) seg = i;
    m = (seg < 2) ? ((v >> 1) & 15) : ((v >> seg) & 15);
    return 8'(((seg << 4) | m) ^ mask);
  endfunction

  function automatic int refMuDec(input logic [7:0] c);
    int u, t;
    u = (~c) & 255;
    t = ((u & 15) << 3) + 132;
    t = t << ((u >> 4) & 7);
    return ((u & 128) != 0) ? (132 - t) / 4 : (t - 132) / 4;
  endfunction

  function automatic int refADec(input logic [7:0] c);
    int a, t, s;
    a = c ^ 'h55;
    t = (a & 15) << 4;
    s = (a >> 4) & 7;
    if (s == 0) t = t + 8;
    else t = (t + 264) << (s - 1);
    return ((a & 128) != 0) ? t / 4 : -t / 4;
  endfunction

  function automatic logic [15:0] expTxWord(input logic [1:0] f, input logic [13:0] s);
    int x;
    x = int'($signed(s));
    if (f[1]) return {s[13], s[13], s};
    if (f == 2'b01) return {8'h00, refMuEnc(x)};
    return {8'h00, refAEnc(x)};
  endfunction

  function automatic logic [13:0] expRx(input logic [1:0] f, input logic [15:0] w);
    if (f[1]) return w[13:0];
    if (f == 2'b01) return 14'(refMuDec(w[7:0]));
    return 14'(refADec(w[7:0]));
  endfunction

  function automatic string txReq(input logic [1:0] f);
    if (f[1]) return "R6";
    if (f == 2'b01) return "R7";
    return "R8";
  endfunction

  // one frame; chg changes fmtSel in the middle (R2)
  task automatic runFrame(input logic [1:0] f, input logic al, input logic [13:0] tx,
                          input logic [15:0] rxw, input logic chg);
    int n, off;
    logic [15:0] gotTx;
    logic [15:0] sent;
    logic [15:0] expWord;
    logic winOk;
    n = f[1] ? 16 : 8;
    off = al ? 0 : 1;
    gotTx = '0;
    winOk = 1'b1;
    sent = f[1] ? rxw : {8'h00, rxw[7:0]};
    expWord = expTxWord(f, tx);
    @(negedge clk);
    fs = 1'b1; fmtSel = f; alignFs = al; txSample = tx;
    for (int c = 0; c < n + off + 3; c++) begin
      int k;
      @(negedge clk);
      k = c - off;
      if (c == 2) fs = 1'b0;
      if (chg && k == 2) fmtSel = f ^ 2'b11;
      if (k == -1) check("R4", "oe before delayed start", {31'd0, dxOe}, 32'd0);
      if (k == 0) check(al ? "R3" : "R4", "oe at first slot", {31'd0, dxOe}, 32'd1);
      if (k >= 0 && k < n) begin
        if (!dxOe) winOk = 1'b0;
        gotTx = {gotTx[14:0], dx};
        dr = sent[n - 1 - k];
      end
      if (k == n) begin
        dr = 1'b0;
        check("R5", "window length and idle line", {30'd0, winOk, dxOe | dx}, {30'd0, 1'b1, 1'b0});
        check(chg ? "R2" : txReq(f), "tx word", {16'd0, gotTx}, {16'd0, expWord});
        check("R10", "valid strobe", {31'd0, rxValid}, 32'd1);
        check(chg ? "R2" : (f[1] ? "R6" : "R9"), "rx sample", {18'd0, rxSample},
              {18'd0, expRx(f, sent)});
      end
      if (k == n + 1) check("R10", "strobe single cycle", {31'd0, rxValid}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1", "oe in reset", {31'd0, dxOe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "outputs after reset", {16'd0, dx, dxOe, rxValid, frameErr, 12'd0},
          32'd0);
    check("R1", "rx sample after reset", {18'd0, rxSample}, 32'd0);

    // directed corners
    runFrame(2'b01, 1'b1, 14'h1FFF, 16'h0000, 1'b0);
    runFrame(2'b01, 1'b0, 14'h2000, 16'h00FF, 1'b0);
    runFrame(2'b01, 1'b1, 14'd8159, 16'h0080, 1'b0);
    runFrame(2'b01, 1'b1, 14'd8160, 16'h007F, 1'b0);
    runFrame(2'b01, 1'b0, 14'h0000, 16'h0000, 1'b0);
    runFrame(2'b00, 1'b1, 14'h0000, 16'h0055, 1'b0);
    runFrame(2'b00, 1'b0, 14'h3FFF, 16'h00D5, 1'b0);
    runFrame(2'b00, 1'b1, 14'h1FFF, 16'h0080, 1'b0);
    runFrame(2'b00, 1'b1, 14'h2000, 16'h00FF, 1'b0);
    runFrame(2'b10, 1'b1, 14'h2001, 16'hC123, 1'b0);
    runFrame(2'b11, 1'b0, 14'h1ABC, 16'h3FFF, 1'b0);
    runFrame(2'b00, 1'b1, 14'h0123, 16'h00A7, 1'b1);
    runFrame(2'b10, 1'b0, 14'h2345, 16'h8001, 1'b1);
    check("R11", "no error after whole frames", {31'd0, frameErr}, 32'd0);

    // early sync restarts a frame (R11)
    @(negedge clk); fs = 1'b1; fmtSel = 2'b01; alignFs = 1'b1; txSample = 14'h0777;
    @(negedge clk);
    @(negedge clk); fs = 1'b0;
    @(negedge clk);
    check("R11", "flag before early sync", {31'd0, frameErr}, 32'd0);
    runFrame(2'b00, 1'b1, 14'h1357, 16'h003C, 1'b0);
    check("R11", "flag after early sync", {31'd0, frameErr}, 32'd1);
    runFrame(2'b10, 1'b0, 14'h0F0F, 16'h1234, 1'b0);
    check("R11", "flag sticky", {31'd0, frameErr}, 32'd1);

    // random frames
    for (int i = 0; i < 250; i++) begin
      logic [1:0] f;
      logic al;
      logic [13:0] tx;
      logic [15:0] rw;
      f  = 2'($urandom % 4);
      al = 1'($urandom % 2);
      tx = 14'($urandom);
      rw = 16'($urandom);
      runFrame(f, al, tx, rw, ($urandom % 6) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule